// File: doc/BRIEF.md
# Masked-write GPIO port registers

This block holds the control state of one port of general-purpose pins and gives software a way to change single pins with one store. Each pin has three writable bits: a configure bit that puts the pin under GPIO control instead of an alternate function, an output-enable bit, and an output value. A fourth, read-only register returns the pad levels after a two-flop synchronizer. The block drives the pad output value and the pad output-enable lines.

Each writable register can be reached at two addresses. The plain address replaces the whole register. The masked address, placed a fixed parameterised distance above the plain one, carries a per-pin mask in the upper byte of the write data and new values in the lower byte. A set mask bit updates that pin, and a clear mask bit leaves it alone. Two agents can then own different pins of the same port without a read-modify-write race.

The bus is a valid/ready command channel and a valid/ready response channel. A command moves when `cmd_valid` and `cmd_ready` are both high at a clock edge. Every accepted command, read or write, returns exactly one response beat one cycle later. The response holds its value until `rsp_ready` takes it. `cmd_ready` stays low while a response is waiting and `rsp_ready` is low, so back-pressure on the response channel stalls new commands. The port's window starts at `BANK_IDX*BANK_STRIDE + PORT_IDX*4`.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset, configure, output enable and output value are all 0, `pad_oe` and `pad_out` are 0, and `rsp_valid` is 0.
- R2: A write to the plain alias (window offset 0x00 configure, 0x10 output enable, 0x20 output value) replaces all pins with write data bits 7:0. Bits 31:8 are ignored.
- R3: A write to the masked alias (same offset plus `MASK_OFFSET`) sets pin n to write data bit n when write data bit 8+n is 1.
- R4: In a masked write, every pin whose mask bit (bit 8+n) is 0 keeps its previous value. An all-zero mask changes nothing.
- R5: A read of a plain alias returns that register in bits 7:0, with bits 31:8 zero.
- R6: A read of offset 0x30 returns the pad levels through a two-flop synchronizer, whatever the output-enable setting. A pad change is visible to a read accepted on the third rising edge after the change.
- R7: `pad_oe[n]` is 1 only when both configure bit n and output-enable bit n are 1. `pad_out` follows the output value register.
- R8: Reads of unmapped offsets, including the masked aliases and the masked input offset, return zero. Writes to the input offset or to unmapped offsets change no register.
- R9: Only addresses inside this port's window decode. Accesses at the neighbouring port's offsets or at another bank's offsets are unmapped.
- R10: Each accepted command gives one response with `rsp_valid` high in the next cycle. While `rsp_ready` is low, `rsp_valid` and `rsp_rdata` hold and `cmd_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command beat offered |
| cmd_ready | output | 1 | Command beat can be taken |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Byte address |
| cmd_wdata | input | DATA_W | Write data (mask in 15:8, values in 7:0 for masked aliases) |
| rsp_valid | output | 1 | Response beat offered |
| rsp_ready | input | 1 | Response beat can be taken |
| rsp_rdata | output | DATA_W | Read data (zero for writes) |
| pad_in | input | PINS | Asynchronous pad levels |
| pad_out | output | PINS | Pad output values |
| pad_oe | output | PINS | Pad output enables |

## Verification
The bench builds the port with `BANK_IDX=1`, `PORT_IDX=2`, `BANK_STRIDE=0x100` and `MASK_OFFSET=0x80`, so the window starts at 0x108 rather than zero. With that base, the bench can put addresses of the neighbouring port (0x104, 0x12C) and of the next bank (0x218) on the bus and show that the base arithmetic really separates them. `PINS=8` keeps the mask in bits 15:8. The vector table also covers masked writes with disjoint masks, with an empty mask, and with a mask that clears bits already set.

// File: rtl/gpm_pkg.sv
package gpm_pkg;
  // number of writable per-pin registers
  localparam int NUM_RW    = 3;
  // spacing of registers inside a port window
  localparam int REG_STEP  = 16;
  // spacing of consecutive port windows
  localparam int PORT_STEP = 4;
  // slot of the read-only input register
  localparam int IN_SLOT   = 3;

  typedef enum int unsigned {
    SLOT_CNF = 0,
    SLOT_OE  = 1,
    SLOT_OUT = 2
  } rw_slot_e;
endpackage

// File: rtl/gpm_decode.sv
module gpm_decode
  import gpm_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int BANK_IDX    = 0,
  parameter int PORT_IDX    = 0,
  parameter int BANK_STRIDE = 256,
  parameter int MASK_OFFSET = 128
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_RW-1:0] hit_plain,
  output logic [NUM_RW-1:0] hit_mask,
  output logic              hit_in
);
  localparam int BASE = BANK_IDX * BANK_STRIDE + PORT_IDX * PORT_STEP;
  localparam logic [ADDR_W-1:0] IN_ADDR = ADDR_W'(BASE + IN_SLOT * REG_STEP);

  for (genvar g = 0; g < NUM_RW; g++) begin : g_slot
    localparam logic [ADDR_W-1:0] PLAIN_ADDR = ADDR_W'(BASE + g * REG_STEP);
    localparam logic [ADDR_W-1:0] MASK_ADDR  = ADDR_W'(BASE + MASK_OFFSET + g * REG_STEP);
    assign hit_plain[g] = (addr == PLAIN_ADDR);
    assign hit_mask[g]  = (addr == MASK_ADDR);
  end

  assign hit_in = (addr == IN_ADDR);
endmodule

// File: rtl/gpm_sync.sv
module gpm_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/gpm_maskreg.sv
module gpm_maskreg #(
  parameter int PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_all,
  input  logic              wr_msk,
  input  logic [2*PINS-1:0] wdata,
  output logic [PINS-1:0]   q
);
  logic [PINS-1:0] sel_mask;
  logic [PINS-1:0] new_val;
  logic [PINS-1:0] nxt;

  assign sel_mask = wdata[2*PINS-1:PINS];
  assign new_val  = wdata[PINS-1:0];

  always_comb begin
    nxt = q;
    if (wr_all)      nxt = new_val;
    else if (wr_msk) nxt = (q & ~sel_mask) | (new_val & sel_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_msk && !wr_all) |=> (((q ^ $past(q)) & ~$past(sel_mask)) == '0)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_msk && !wr_all) |=> $stable(q)); // R8
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpm_pkg::*;
#(
  parameter int PINS        = 8,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int BANK_IDX    = 0,
  parameter int PORT_IDX    = 0,
  parameter int BANK_STRIDE = 256,
  parameter int MASK_OFFSET = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe
);
  logic [NUM_RW-1:0]           hit_plain;
  logic [NUM_RW-1:0]           hit_mask;
  logic                        hit_in;
  logic                        accept;
  logic [NUM_RW-1:0][PINS-1:0] regs;
  logic [PINS-1:0]             pad_sync;
  logic [DATA_W-1:0]           rd_mux;
  logic                        unused_wdata_hi;

  assign unused_wdata_hi = ^cmd_wdata[DATA_W-1:2*PINS];

  gpm_decode #(
    .ADDR_W     (ADDR_W),
    .BANK_IDX   (BANK_IDX),
    .PORT_IDX   (PORT_IDX),
    .BANK_STRIDE(BANK_STRIDE),
    .MASK_OFFSET(MASK_OFFSET)
  ) u_decode (
    .addr     (cmd_addr),
    .hit_plain(hit_plain),
    .hit_mask (hit_mask),
    .hit_in   (hit_in)
  );

  gpm_sync #(.WIDTH(PINS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_in),
    .q    (pad_sync)
  );

  assign cmd_ready = !rsp_valid || rsp_ready;
  assign accept    = cmd_valid && cmd_ready;

  for (genvar g = 0; g < NUM_RW; g++) begin : g_reg
    gpm_maskreg #(.PINS(PINS)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_all(accept && cmd_write && hit_plain[g]),
      .wr_msk(accept && cmd_write && hit_mask[g]),
      .wdata (cmd_wdata[2*PINS-1:0]),
      .q     (regs[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_RW; i++) begin
      if (hit_plain[i]) rd_mux[PINS-1:0] = regs[i];
    end
    if (hit_in) rd_mux[PINS-1:0] = pad_sync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= cmd_write ? '0 : rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign pad_out = regs[SLOT_OUT];
  assign pad_oe  = regs[SLOT_CNF] & regs[SLOT_OE];

  AST_ACCEPT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid); // R10

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R10

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cmd_write && !(|hit_plain) && !hit_in) |=> (rsp_rdata == '0)); // R8

  AST_INPUT_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_write && hit_in) |=> $stable(regs)); // R8
endmodule

// File: tb/gpio_mask_port_bench.sv
module gpio_mask_port_bench;
  localparam int PINS = 8;
  localparam int AW   = 12;
  localparam int DW   = 32;
  localparam int NV   = 23;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic          cmd_write = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [DW-1:0] rsp_rdata;
  logic [PINS-1:0] pad_in = '0;
  logic [PINS-1:0] pad_out;
  logic [PINS-1:0] pad_oe;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  gpio_mask_port #(
    .PINS(PINS), .ADDR_W(AW), .DATA_W(DW),
    .BANK_IDX(1), .PORT_IDX(2), .BANK_STRIDE(256), .MASK_OFFSET(128)
  ) u_gpio_mask_port (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // {write, addr, wdata, expected byte, requirement number}
  localparam logic [56:0] VEC [0:NV-1] = '{
    {1'b1, 12'h108, 32'hFFFF_FF3C, 8'h00, 4'd2},  // R2 plain configure, upper bits ignored
    {1'b0, 12'h108, 32'h0,         8'h3C, 4'd5},  // R5
    {1'b1, 12'h118, 32'h0000_000F, 8'h00, 4'd2},  // R2
    {1'b0, 12'h118, 32'h0,         8'h0F, 4'd5},  // R5
    {1'b1, 12'h1A8, 32'h0000_F0AA, 8'h00, 4'd3},  // R3 masked output, upper nibble
    {1'b0, 12'h128, 32'h0,         8'hA0, 4'd3},  // R3
    {1'b1, 12'h1A8, 32'h0000_0F55, 8'h00, 4'd4},  // R4 lower nibble, upper kept
    {1'b0, 12'h128, 32'h0,         8'hA5, 4'd4},  // R4
    {1'b1, 12'h188, 32'h0000_0C00, 8'h00, 4'd3},  // R3 masked clear of bits 3:2
    {1'b0, 12'h108, 32'h0,         8'h30, 4'd3},  // R3
    {1'b1, 12'h198, 32'h0000_00FF, 8'h00, 4'd4},  // R4 empty mask
    {1'b0, 12'h118, 32'h0,         8'h0F, 4'd4},  // R4
    {1'b0, 12'h138, 32'h0,         8'hA5, 4'd6},  // R6 input view
    {1'b1, 12'h138, 32'h0000_00FF, 8'h00, 4'd8},  // R8 write to input offset
    {1'b0, 12'h128, 32'h0,         8'hA5, 4'd8},  // R8
    {1'b0, 12'h100, 32'h0,         8'h00, 4'd8},  // R8 unmapped
    {1'b0, 12'h1B8, 32'h0,         8'h00, 4'd8},  // R8 masked input offset
    {1'b1, 12'h12C, 32'h0000_00FF, 8'h00, 4'd9},  // R9 neighbour port output
    {1'b0, 12'h128, 32'h0,         8'hA5, 4'd9},  // R9
    {1'b1, 12'h104, 32'hFFFF_FFFF, 8'h00, 4'd9},  // R9 neighbour port configure
    {1'b0, 12'h108, 32'h0,         8'h30, 4'd9},  // R9
    {1'b0, 12'h188, 32'h0,         8'h00, 4'd8},  // R8 masked alias reads zero
    {1'b0, 12'h218, 32'h0,         8'h00, 4'd9}   // R9 other bank
  };

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic txn(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     output logic [DW-1:0] rd);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_write = wr;
    cmd_addr  = a;
    cmd_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    rd = rsp_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    logic [DW-1:0] held;
    pad_in = 8'hA5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pad_oe", {24'h0, pad_oe}, 32'h0);
    chk("R1 pad_out", {24'h0, pad_out}, 32'h0);
    chk("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    txn(1'b0, 12'h118, 32'h0, rd);
    chk("R1 oe reg", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      txn(VEC[i][56], VEC[i][55:44], VEC[i][43:12], rd);
      if (!VEC[i][56]) chk($sformatf("R%0d vector %0d", VEC[i][3:0], i), rd, {24'h0, VEC[i][11:4]});
    end

    // R7 pads: configure 30, enable 0F -> no drive
    chk("R7 pad_oe disjoint", {24'h0, pad_oe}, 32'h0);
    chk("R7 pad_out", {24'h0, pad_out}, 32'hA5);
    txn(1'b1, 12'h198, 32'h0000_3030, rd);
    chk("R7 pad_oe masked enable", {24'h0, pad_oe}, 32'h30);
    txn(1'b1, 12'h108, 32'h0000_00FF, rd);
    chk("R7 pad_oe full configure", {24'h0, pad_oe}, 32'h3F);

    // R6 input seen through synchronizer while some pins drive
    @(negedge clk);
    pad_in = 8'h5A;
    @(posedge clk);
    @(posedge clk);
    txn(1'b0, 12'h138, 32'h0, rd);
    chk("R6 input after sync", rd, 32'h5A);

    // R10 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    cmd_valid = 1'b1;
    cmd_write = 1'b0;
    cmd_addr  = 12'h118;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R10 rsp_valid", {31'h0, rsp_valid}, 32'h1);
    chk("R10 cmd_ready low", {31'h0, cmd_ready}, 32'h0);
    held = rsp_rdata;
    chk("R10 data", held, 32'h3F);
    repeat (2) @(negedge clk);
    chk("R10 held", rsp_rdata, held);
    chk("R10 still valid", {31'h0, rsp_valid}, 32'h1);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R10 drained", {31'h0, rsp_valid}, 32'h0);
    chk("R10 cmd_ready back", {31'h0, cmd_ready}, 32'h1);

    // R1 reset in the middle of operation
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pad_oe after reset", {24'h0, pad_oe}, 32'h0);
    chk("R1 pad_out after reset", {24'h0, pad_out}, 32'h0);
    txn(1'b0, 12'h108, 32'h0, rd);
    chk("R1 configure after reset", rd, 32'h0);
    txn(1'b0, 12'h128, 32'h0, rd);
    chk("R1 output after reset", rd, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule